// File: doc/BRIEF.md
# Banked GPIO Register File

This block is the register file of a general purpose I/O controller with a parameterised pin count (94 by default). One 32-bit read/write bus reaches two kinds of register in a single address space.

- **Bank bitmaps** sit at the low offsets. Each holds one bit per pin, 32 pins to a word: pin ownership, interrupt status and interrupt enable.
- **Configuration words** come as a pair per pin, starting at 0x100 with a stride of 8 bytes.

The block drives each pin's output value and output enable. It also exports the following to a separate interrupt unit:

- the trigger-mode bits of each pin;
- each pin's synchronised, sensing-gated input level;
- the pull selection;
- the interrupt enable bits;
- the selection between two upstream interrupt lines.

The interrupt unit reports pin events back through `int_set`. Those events become status bits, and software clears them by writing one.

Software asks for a pin by checking its ownership bit, setting the use-select bit, turning input sensing on, and then choosing direction and level. Pad electrical behaviour is outside this block. The pull field is only stored and passed on.

Top module: `gpio_bank_regs`

## Requirements
- R1: A bank register of pin p is at its base plus 4*(p/32), bit p%32. The bases are: ownership 0x00, interrupt status 0x80, interrupt enable 0x90. Bits above the last pin read 0 and cannot be set.
- R2: Ownership bits reset to the `OWN_RESET` parameter (all ones: available to software) and stay writable.
- R3: Configuration word A of pin n is at 0x100+8n. Its fields are:
  - bit 31: output level;
  - bit 30: input level, read-only;
  - bit 4: trigger type, 1 = level;
  - bit 3: trigger invert;
  - bit 2: direction, 1 = input;
  - bit 0: use select, 1 = GPIO.

  All other bits read 0. It resets to 0x00000004.
- R4: Configuration word B of pin n is at 0x104+8n. Bit 2 turns input sensing off and bits 1:0 hold the pull option. It resets to 0x00000004. The pull option of pin n appears on `pull_sel[2n+1:2n]`.
- R5: `pin_out[n]` follows the output-level bit. `pin_oe[n]` is 1 only when use select is 1 and direction is 0.
- R6: Pin inputs pass through two flops before they reach bit 30 or `sense_level`.
- R7: With sensing off, bit 30 reads 0 and `sense_level[n]` is 0.
- R8: `trig_level_mode[n]` and `trig_invert[n]` follow bits 4 and 3 of word A.
- R9: A status bit is set by `int_set` and cleared by writing 1 to it. A set in the same cycle as a clear wins. The enable bits are read/write and appear on `int_en`.
- R10: Bit 0 of the word at 0x7C drives `irq_sel`. Its other bits read 0.
- R11: Reads of unmapped or non-word-aligned addresses return 0, and writes to them change nothing. Read data appears in the cycle after the read and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| pin_in | input | NUM_PINS | Raw pin levels |
| pin_out | output | NUM_PINS | Output levels |
| pin_oe | output | NUM_PINS | Output enables |
| sense_level | output | NUM_PINS | Synchronised, sensing-gated input levels |
| trig_level_mode | output | NUM_PINS | 1 = level trigger |
| trig_invert | output | NUM_PINS | Trigger inversion |
| pull_sel | output | 2*NUM_PINS | Pull option, two bits per pin |
| int_set | input | NUM_PINS | Event pulses from the interrupt unit |
| int_en | output | NUM_PINS | Interrupt enable bits |
| irq_sel | output | 1 | Upstream interrupt line select |

## Verification
The bench builds the block with its default 94 pins and 12 address bits. That gives three bank words, with a last word only 30 bits full, so writes of ones to the unused top bits of bank 2 can be checked to read back as 0. The first address past the last pin pair (0x3F0) is in range and is shown to be unmapped. Random configuration traffic over all 94 pins, with random held input levels, exercises the pin-index decode across the whole stride-8 region. Directed cases cover the status set-versus-clear race, misaligned writes, and turning sensing on and off.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Byte offsets of the register groups
    localparam int unsigned OFS_OWN  = 'h000;
    localparam int unsigned OFS_GLB  = 'h07C;
    localparam int unsigned OFS_STAT = 'h080;
    localparam int unsigned OFS_EN   = 'h090;
    localparam int unsigned OFS_PIN  = 'h100;

    typedef struct packed {
        logic out_lvl;
        logic trig_level;
        logic trig_inv;
        logic dir_in;
        logic use_gpio;
    } cfg1_t;

    typedef struct packed {
        logic       sense_off;
        logic [1:0] pull;
    } cfg2_t;

    typedef enum logic [2:0] {
        RK_NONE, RK_OWN, RK_GLB, RK_STAT, RK_EN, RK_CFG1, RK_CFG2
    } reg_kind_t;

    localparam cfg1_t CFG1_RST = '{out_lvl: 1'b0, trig_level: 1'b0, trig_inv: 1'b0,
                                   dir_in: 1'b1, use_gpio: 1'b0};
    localparam cfg2_t CFG2_RST = '{sense_off: 1'b1, pull: 2'b00};

    function automatic cfg1_t cfg1_from_word(logic [31:0] w);
        cfg1_t c;
        c.out_lvl    = w[31];
        c.trig_level = w[4];
        c.trig_inv   = w[3];
        c.dir_in     = w[2];
        c.use_gpio   = w[0];
        return c;
    endfunction

    function automatic cfg2_t cfg2_from_word(logic [31:0] w);
        cfg2_t c;
        c.sense_off = w[2];
        c.pull      = w[1:0];
        return c;
    endfunction

    function automatic logic [31:0] cfg1_to_word(cfg1_t c, logic in_lvl);
        return {c.out_lvl, in_lvl, 25'b0, c.trig_level, c.trig_inv, c.dir_in, 1'b0, c.use_gpio};
    endfunction

    function automatic logic [31:0] cfg2_to_word(cfg2_t c);
        return {29'b0, c.sense_off, c.pull};
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int unsigned WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

    // R6: output equals the input of two cycles earlier
    a_r6_two_stage: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (q == $past(d, 2)));

endmodule

// File: rtl/gpio_bitmap_regs.sv
module gpio_bitmap_regs #(
    parameter int unsigned         NUM_PINS     = 94,
    parameter int unsigned         BANK_IW      = 2,
    parameter bit                  CLEAR_ON_ONE = 1'b0,
    parameter logic [NUM_PINS-1:0] RESET_VAL    = '0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [BANK_IW-1:0]  bank,
    input  logic [31:0]         wdata,
    input  logic [NUM_PINS-1:0] set,
    output logic [NUM_PINS-1:0] q
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
        localparam int unsigned BK = i / 32;
        localparam int unsigned BT = i % 32;
        logic hit;
        logic r;
        assign hit  = we && (bank == BANK_IW'(BK));
        assign q[i] = r;
        if (CLEAR_ON_ONE) begin : g_w1c
            always_ff @(posedge clk) begin
                if (rst) r <= RESET_VAL[i];
                else     r <= set[i] | (r & ~(hit & wdata[BT]));
            end
        end else begin : g_rw
            always_ff @(posedge clk) begin
                if (rst)         r <= RESET_VAL[i];
                else if (set[i]) r <= 1'b1;
                else if (hit)    r <= wdata[BT];
            end
        end
    end

    // R9: a set request always leaves its bit at 1, whatever the bus does
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        (|set) |=> ((q & $past(set)) == $past(set)));

endmodule

// File: rtl/gpio_pin_cfg.sv
module gpio_pin_cfg
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_PINS = 94,
    parameter int unsigned PIN_IW   = 7
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we1,
    input  logic                       we2,
    input  logic [PIN_IW-1:0]          pin,
    input  cfg1_t                      wr1,
    input  cfg2_t                      wr2,
    output cfg1_t [NUM_PINS-1:0]       c1,
    output cfg2_t [NUM_PINS-1:0]       c2
);
    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        logic sel;
        cfg1_t r1;
        cfg2_t r2;
        assign sel   = (pin == PIN_IW'(n));
        assign c1[n] = r1;
        assign c2[n] = r2;
        always_ff @(posedge clk) begin
            if (rst) begin
                r1 <= CFG1_RST;
                r2 <= CFG2_RST;
            end else begin
                if (we1 && sel) r1 <= wr1;
                if (we2 && sel) r2 <= wr2;
            end
        end
    end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned         NUM_PINS  = 94,
    parameter int unsigned         ADDR_W    = 12,
    parameter logic [NUM_PINS-1:0] OWN_RESET = '1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NUM_PINS-1:0]   pin_in,
    output logic [NUM_PINS-1:0]   pin_out,
    output logic [NUM_PINS-1:0]   pin_oe,
    output logic [NUM_PINS-1:0]   sense_level,
    output logic [NUM_PINS-1:0]   trig_level_mode,
    output logic [NUM_PINS-1:0]   trig_invert,
    output logic [2*NUM_PINS-1:0] pull_sel,
    input  logic [NUM_PINS-1:0]   int_set,
    output logic [NUM_PINS-1:0]   int_en,
    output logic                  irq_sel
);
    localparam int unsigned NUM_BANKS = (NUM_PINS + 31) / 32;
    localparam int unsigned BANK_IW   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int unsigned PIN_IW    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam int unsigned PAD_W     = NUM_BANKS * 32;

    // ---------------- address decode ----------------
    reg_kind_t          kind;
    logic [BANK_IW-1:0] bank;
    logic [PIN_IW-1:0]  pin;
    logic [ADDR_W-1:0]  pin_off;

    always_comb begin
        kind    = RK_NONE;
        bank    = '0;
        pin     = '0;
        pin_off = bus_addr - ADDR_W'(OFS_PIN);
        if (bus_addr[1:0] == 2'b00) begin
            if (bus_addr >= ADDR_W'(OFS_PIN)) begin
                if ((pin_off >> 3) < ADDR_W'(NUM_PINS)) begin
                    kind = bus_addr[2] ? RK_CFG2 : RK_CFG1;
                    pin  = PIN_IW'(pin_off >> 3);
                end
            end else if (bus_addr == ADDR_W'(OFS_GLB)) begin
                kind = RK_GLB;
            end else if (bus_addr >= ADDR_W'(OFS_STAT) &&
                         bus_addr <  ADDR_W'(OFS_STAT + 4 * NUM_BANKS)) begin
                kind = RK_STAT;
                bank = BANK_IW'((bus_addr - ADDR_W'(OFS_STAT)) >> 2);
            end else if (bus_addr >= ADDR_W'(OFS_EN) &&
                         bus_addr <  ADDR_W'(OFS_EN + 4 * NUM_BANKS)) begin
                kind = RK_EN;
                bank = BANK_IW'((bus_addr - ADDR_W'(OFS_EN)) >> 2);
            end else if (bus_addr < ADDR_W'(OFS_OWN + 4 * NUM_BANKS)) begin
                kind = RK_OWN;
                bank = BANK_IW'((bus_addr - ADDR_W'(OFS_OWN)) >> 2);
            end
        end
    end

    logic wr_go;
    assign wr_go = bus_sel && bus_wr;

    // ---------------- storage ----------------
    logic [NUM_PINS-1:0] own_q, stat_q;

    gpio_bitmap_regs #(.NUM_PINS(NUM_PINS), .BANK_IW(BANK_IW), .CLEAR_ON_ONE(1'b0),
                       .RESET_VAL(OWN_RESET)) u_own (
        .clk(clk), .rst(rst), .we(wr_go && kind == RK_OWN), .bank(bank),
        .wdata(bus_wdata), .set('0), .q(own_q));

    gpio_bitmap_regs #(.NUM_PINS(NUM_PINS), .BANK_IW(BANK_IW), .CLEAR_ON_ONE(1'b1),
                       .RESET_VAL('0)) u_stat (
        .clk(clk), .rst(rst), .we(wr_go && kind == RK_STAT), .bank(bank),
        .wdata(bus_wdata), .set(int_set), .q(stat_q));

    gpio_bitmap_regs #(.NUM_PINS(NUM_PINS), .BANK_IW(BANK_IW), .CLEAR_ON_ONE(1'b0),
                       .RESET_VAL('0)) u_en (
        .clk(clk), .rst(rst), .we(wr_go && kind == RK_EN), .bank(bank),
        .wdata(bus_wdata), .set('0), .q(int_en));

    cfg1_t [NUM_PINS-1:0] c1;
    cfg2_t [NUM_PINS-1:0] c2;

    gpio_pin_cfg #(.NUM_PINS(NUM_PINS), .PIN_IW(PIN_IW)) u_cfg (
        .clk(clk), .rst(rst),
        .we1(wr_go && kind == RK_CFG1), .we2(wr_go && kind == RK_CFG2), .pin(pin),
        .wr1(cfg1_from_word(bus_wdata)), .wr2(cfg2_from_word(bus_wdata)),
        .c1(c1), .c2(c2));

    always_ff @(posedge clk) begin
        if (rst)                        irq_sel <= 1'b0;
        else if (wr_go && kind == RK_GLB) irq_sel <= bus_wdata[0];
    end

    logic [NUM_PINS-1:0] sync_q;
    gpio_sync2 #(.WIDTH(NUM_PINS)) u_sync (.clk(clk), .rst(rst), .d(pin_in), .q(sync_q));

    // ---------------- pin outputs ----------------
    for (genvar n = 0; n < NUM_PINS; n++) begin : g_out
        assign pin_out[n]         = c1[n].out_lvl;
        assign pin_oe[n]          = c1[n].use_gpio & ~c1[n].dir_in;
        assign sense_level[n]     = sync_q[n] & ~c2[n].sense_off;
        assign trig_level_mode[n] = c1[n].trig_level;
        assign trig_invert[n]     = c1[n].trig_inv;
        assign pull_sel[2*n +: 2] = c2[n].pull;
    end

    // ---------------- read path ----------------
    function automatic logic [31:0] pick(logic [PAD_W-1:0] v, logic [BANK_IW-1:0] b);
        return v[32*b +: 32];
    endfunction

    logic [31:0] rd;
    always_comb begin
        unique case (kind)
            RK_OWN:  rd = pick(PAD_W'(own_q), bank);
            RK_STAT: rd = pick(PAD_W'(stat_q), bank);
            RK_EN:   rd = pick(PAD_W'(int_en), bank);
            RK_GLB:  rd = {31'b0, irq_sel};
            RK_CFG1: rd = cfg1_to_word(c1[pin], sense_level[pin]);
            RK_CFG2: rd = cfg2_to_word(c2[pin]);
            default: rd = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else     bus_rdata <= (bus_sel && !bus_wr) ? rd : '0;
    end

    // ---------------- assertions ----------------
    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && kind == RK_NONE) |=> (bus_rdata == '0));

    a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && !bus_wr) |=> (bus_rdata == '0));

    a_r5_oe_after_write: assert property (@(posedge clk) disable iff (rst)
        (wr_go && kind == RK_CFG1) |=>
        (pin_oe[$past(pin)] == ($past(bus_wdata[0]) && !$past(bus_wdata[2]))));

    a_r5_out_after_write: assert property (@(posedge clk) disable iff (rst)
        (wr_go && kind == RK_CFG1) |=> (pin_out[$past(pin)] == $past(bus_wdata[31])));

    a_r7_sense_off: assert property (@(posedge clk) disable iff (rst)
        (wr_go && kind == RK_CFG2 && bus_wdata[2]) |=> !sense_level[$past(pin)]);

    a_r10_line_sel: assert property (@(posedge clk) disable iff (rst)
        (wr_go && kind == RK_GLB) |=> (irq_sel == $past(bus_wdata[0])));

endmodule

// File: tb/tb_gpio_bank_regs.sv
`timescale 1ns/1ps
module tb_gpio_bank_regs;
    localparam int NP = 94;
    localparam int AW = 12;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            sel = 1'b0, wr = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [31:0]     wdata = '0, rdata;
    logic [NP-1:0]   pin_in = '0, pin_out, pin_oe, sense_level, trig_level_mode, trig_invert;
    logic [2*NP-1:0] pull_sel;
    logic [NP-1:0]   int_set = '0, int_en;
    logic            irq_sel;

    always #4 clk = ~clk;

    gpio_bank_regs dut (
        .clk(clk), .rst(rst), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .sense_level(sense_level), .trig_level_mode(trig_level_mode),
        .trig_invert(trig_invert), .pull_sel(pull_sel), .int_set(int_set),
        .int_en(int_en), .irq_sel(irq_sel));

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] m_c1 [NP];
    logic [2:0]  m_c2 [NP];

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk); sel = 1'b0; d = rdata;
    endtask

    function automatic logic [AW-1:0] c1_addr(int p); return AW'(32'h100 + 8 * p); endfunction
    function automatic logic [AW-1:0] c2_addr(int p); return AW'(32'h104 + 8 * p); endfunction

    function automatic logic [31:0] exp_c1(int p);
        logic inl;
        inl = pin_in[p] & ~m_c2[p][2];
        return {m_c1[p][31], inl, 25'b0, m_c1[p][4:2], 1'b0, m_c1[p][0]};
    endfunction

    task automatic wr_c1(int p, logic [31:0] w);
        bus_write(c1_addr(p), w);
        m_c1[p] = w;
    endtask

    task automatic wr_c2(int p, logic [31:0] w);
        bus_write(c2_addr(p), w);
        m_c2[p] = w[2:0];
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        for (int p = 0; p < NP; p++) begin m_c1[p] = 32'h4; m_c2[p] = 3'b100; end
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R2 / R1: reset ownership, last bank holds 30 pins
        bus_read(12'h000, d); check("R2 own bank0 reset", d, 32'hFFFF_FFFF);
        bus_read(12'h008, d); check("R1 own bank2 reset partial", d, 32'h3FFF_FFFF);
        // R3 / R4 reset values
        bus_read(c1_addr(0), d); check("R3 cfg A reset", d, 32'h4);
        bus_read(c2_addr(93), d); check("R4 cfg B reset", d, 32'h4);
        check("R5 oe reset", {31'b0, |pin_oe}, 32'h0);
        // R11: data is 0 in the cycle after the read
        bus_read(12'h000, d);
        @(negedge clk); check("R11 rdata idle", rdata, 32'h0);

        // R2: ownership writable
        bus_write(12'h004, 32'h1234_5678);
        bus_read(12'h004, d); check("R2 own write", d, 32'h1234_5678);

        // R1: enable bank 2, bits above pin 93 stay 0
        bus_write(12'h098, 32'hFFFF_FFFF);
        bus_read(12'h098, d); check("R1 enable bank2", d, 32'h3FFF_FFFF);
        check("R9 int_en pin93", {31'b0, int_en[93]}, 32'h1);
        check("R9 int_en pin63", {31'b0, int_en[63]}, 32'h0);

        // R9: status set, clear, and set-wins race (pin 40 = bank1 bit 8)
        @(negedge clk); int_set[40] = 1'b1;
        @(negedge clk); int_set[40] = 1'b0;
        bus_read(12'h084, d); check("R9 status set", d, 32'h100);
        bus_write(12'h084, 32'h100);
        bus_read(12'h084, d); check("R9 status cleared", d, 32'h0);
        @(negedge clk); sel = 1'b1; wr = 1'b1; addr = 12'h084; wdata = 32'h100; int_set[40] = 1'b1;
        @(negedge clk); sel = 1'b0; wr = 1'b0; int_set[40] = 1'b0;
        bus_read(12'h084, d); check("R9 set beats clear", d, 32'h100);
        bus_write(12'h084, 32'hFFFF_FFFF);

        // R10: line select
        bus_write(12'h07C, 32'hFFFF_FFFF);
        bus_read(12'h07C, d); check("R10 global word", d, 32'h1);
        check("R10 irq_sel", {31'b0, irq_sel}, 32'h1);

        // R11: unmapped and misaligned accesses
        bus_read(12'h3F0, d); check("R11 past last pin", d, 32'h0);
        bus_read(12'h08C, d); check("R11 missing bank", d, 32'h0);
        bus_write(12'h3F0, 32'hFFFF_FFFF);
        bus_write(12'h101, 32'h8000_0005);
        bus_read(c1_addr(0), d); check("R11 misaligned write ignored", d, 32'h4);
        bus_read(c1_addr(93), d); check("R11 unmapped write ignored", d, 32'h4);

        // R6 / R7: synchroniser and sensing gate on pin 5
        wr_c2(5, 32'h0);
        @(negedge clk); pin_in[5] = 1'b1;
        @(negedge clk); check("R6 not yet through sync", {31'b0, sense_level[5]}, 32'h0);
        @(negedge clk); check("R6 through two flops", {31'b0, sense_level[5]}, 32'h1);
        bus_read(c1_addr(5), d); check("R6 level in word A", d, 32'h4000_0004);
        wr_c2(5, 32'h4);
        bus_read(c1_addr(5), d); check("R7 sensing off reads 0", d, 32'h4);
        check("R7 sense_level gated", {31'b0, sense_level[5]}, 32'h0);

        // R8 / R4 / R5 directed
        wr_c1(7, 32'h0000_0018);
        check("R8 trigger level", {31'b0, trig_level_mode[7]}, 32'h1);
        check("R8 trigger invert", {31'b0, trig_invert[7]}, 32'h1);
        wr_c2(9, 32'h3);
        check("R4 pull export", {30'b0, pull_sel[19:18]}, 32'h3);
        wr_c1(11, 32'h8000_0001);
        check("R5 oe driven", {31'b0, pin_oe[11]}, 32'h1);
        check("R5 out level", {31'b0, pin_out[11]}, 32'h1);

        // Random traffic against the model
        pin_in = {$urandom, $urandom, $urandom};
        repeat (3) @(negedge clk);
        for (int k = 0; k < 80; k++) begin
            int p;
            logic [31:0] w;
            p = $urandom_range(NP - 1);
            w = $urandom;
            if ($urandom_range(1) == 1) begin
                wr_c1(p, w);
                check("R5 random oe", {31'b0, pin_oe[p]}, {31'b0, m_c1[p][0] & ~m_c1[p][2]});
                check("R8 random trig", {30'b0, trig_level_mode[p], trig_invert[p]},
                      {30'b0, m_c1[p][4:3]});
            end else begin
                wr_c2(p, w);
                check("R4 random pull", {30'b0, pull_sel[2*p +: 2]}, {30'b0, m_c2[p][1:0]});
            end
            bus_read(c1_addr(p), d); check("R3 random word A", d, exp_c1(p));
            bus_read(c2_addr(p), d); check("R4 random word B", d, {29'b0, m_c2[p]});
        end

        finish_run();
    end
endmodule